// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block is a watchdog counter for a small processor core. It counts ticks from one of two sources: a free-running low-power oscillator that runs independently of the core, or the system clock divided by four. A prescaler with a parameterised ratio sits in front of a CNT_W-bit counter. When the counter overflows, the block raises a one-cycle time-out pulse, sets a sticky time-out flag and wraps the counter to zero.

Software keeps the watchdog from firing by clearing it. In the plain mode a single clear strobe restarts both the counter and the prescaler. When the paired option is selected, two different clear strobes must both be seen before the restart happens. They may arrive in either order or in the same cycle.

The core signals power-down through a halt level. Entering halt restarts the watchdog. While halted, the watchdog keeps counting if it runs from the oscillator and stands still if it runs from the divided system clock. The oscillator input is brought into the system-clock domain through a two-flop synchroniser with rising-edge detection.

Top module: `wdog_dualclr`

## Requirements
- R1: With src_osc_i low and no clear or halt, time_out_o pulses exactly 4·PRESC·2^CNT_W clock cycles after the edge that samples a completed clear.
- R2: With src_osc_i high, the counter advances once per PRESC rising edges of osc_clk_i, so time_out_o pulses about PRESC·2^CNT_W oscillator periods after a clear.
- R3: With dual_clr_i low, a clr_i strobe restarts the counter, the prescaler and the divide-by-four stage; clr1_i and clr2_i have no effect.
- R4: With dual_clr_i high, the watchdog restarts only once both clr1_i and clr2_i have been seen, in either order or in the same cycle; clr_i has no effect.
- R5: With dual_clr_i high, repeating the same one of clr1_i or clr2_i never completes the pair.
- R6: A half-received pair is discarded when the counter overflows and while dual_clr_i is low.
- R7: On overflow, time_out_o is high for exactly one cycle, the counter wraps to zero, and to_flag_o is high in that same cycle.
- R8: to_flag_o is low after reset and stays set until a completed clear or a halt entry clears it.
- R9: A rising edge on halt_i restarts the counter and prescaler and clears to_flag_o.
- R10: While halt_i is high with src_osc_i low, the count is frozen. After halt_i falls, time_out_o pulses 4·PRESC·2^CNT_W − 1 cycles after the first edge that samples halt_i low.
- R11: While halt_i is high with src_osc_i high, the watchdog keeps counting and can time out during halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_osc_i | input | 1 | 1: count the oscillator, 0: count system clock divided by four |
| dual_clr_i | input | 1 | 1: paired-clear mode, 0: single-clear mode |
| osc_clk_i | input | 1 | Free-running watchdog oscillator, asynchronous to clk |
| halt_i | input | 1 | Core power-down level |
| clr_i | input | 1 | Single clear strobe (one cycle) |
| clr1_i | input | 1 | First paired clear strobe (one cycle) |
| clr2_i | input | 1 | Second paired clear strobe (one cycle) |
| time_out_o | output | 1 | One-cycle overflow pulse |
| to_flag_o | output | 1 | Sticky time-out status |

## Verification
The clear logic is driven by a table of two-command scenarios. Each scenario issues a reference clear, then two later commands in a chosen mode. The cycle of the next time-out then shows which of the three events last restarted the count, so the bench can tell a clear that acted from a clear that was ignored, a completed pair from a repeated half, and mode-gated strobes from live ones. Directed cases then cover the boundary behaviour. One case leaves a half pair pending across an overflow, and another across a trip out of paired mode. Halt is tried with each source: with the divided clock it must freeze the count and give an exact restart latency, and with the oscillator it must run on to a time-out while halted.

// File: rtl/wdog_pkg.sv
// Shared constants for the watchdog block.
package wdog_pkg;
    // Fixed division applied to the system clock when it is the tick source.
    localparam int SYSDIV_RATIO = 4;
    localparam int SYSDIV_W     = $clog2(SYSDIV_RATIO);

    // Encoding of the source select input.
    typedef enum logic {
        SRC_SYSDIV = 1'b0,
        SRC_OSC    = 1'b1
    } wdog_src_e;
endpackage

// File: rtl/wdog_tick_src.sv
// Tick source for the watchdog.
// Produces single-cycle ticks in the clk domain, either from a synchronised
// rising edge of the asynchronous watchdog oscillator, or from a divide-by-
// four of clk. The divider holds while halt_i is high (the system clock is
// taken to be stopped) and restarts on restart_i.
// Assumes osc_clk_i is slower than clk/3, so that every edge is seen.
module wdog_tick_src
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_osc_i,
    input  logic osc_clk_i,
    input  logic halt_i,
    input  logic restart_i,
    output logic tick_o
);
    logic [2:0]          osc_sync_q;
    logic [SYSDIV_W-1:0] div_q;
    logic                osc_tick;
    logic                sys_tick;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) osc_sync_q <= '0;
        else        osc_sync_q <= {osc_sync_q[1:0], osc_clk_i};
    end

    // Divide-by-four stage: restarts on clear, frozen during halt.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) div_q <= '0;
        else if (!halt_i)        div_q <= div_q + 1'b1;
    end

    assign osc_tick = osc_sync_q[1] & ~osc_sync_q[2];
    assign sys_tick = (div_q == SYSDIV_W'(SYSDIV_RATIO - 1)) && !halt_i;
    assign tick_o   = (wdog_src_e'(src_osc_i) == SRC_OSC) ? osc_tick : sys_tick;
endmodule

// File: rtl/wdog_clr_ctl.sv
// Clear-command qualifier.
// In single mode it passes clr_i through. In paired mode it remembers which
// of clr1_i and clr2_i has been seen, and fires once both are present (either
// order, or together). A half pair is dropped on completion, on overflow,
// and whenever paired mode is off.
// Assumes all strobes are one clk cycle wide.
module wdog_clr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_i,
    input  logic clr_i,
    input  logic clr1_i,
    input  logic clr2_i,
    input  logic ovf_i,
    output logic fire_o
);
    logic seen1_q, seen2_q;
    logic got1, got2, pair_done;

    assign got1      = seen1_q | clr1_i;
    assign got2      = seen2_q | clr2_i;
    assign pair_done = got1 & got2;
    assign fire_o    = dual_i ? pair_done : clr_i;

    // Pending-half register: collects strobes until the pair completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !dual_i || ovf_i || pair_done) begin
            seen1_q <= 1'b0;
            seen2_q <= 1'b0;
        end else begin
            seen1_q <= got1;
            seen2_q <= got2;
        end
    end
endmodule

// File: rtl/wdog_count.sv
// Prescaler and watchdog counter.
// Every PRESC ticks advance the CNT_W-bit counter. Stepping from all-ones
// wraps to zero and produces a registered one-cycle time_out_o. ovf_step_o
// is the combinational overflow condition, for the sticky flag.
// Assumes restart_i takes priority over any tick in the same cycle.
module wdog_count #(
    parameter int CNT_W = 16,
    parameter int PRESC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_step_o,
    output logic             time_out_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    generate
        if (PRESC == 1) begin : g_no_presc
            assign step = tick_i;
        end else begin : g_presc
            logic [PW-1:0] presc_q;
            // Prescaler: counts ticks modulo PRESC.
            always_ff @(posedge clk) begin
                if (!rst_n || restart_i) presc_q <= '0;
                else if (tick_i)
                    presc_q <= (presc_q == PW'(PRESC - 1)) ? '0 : presc_q + 1'b1;
            end
            assign step = tick_i && (presc_q == PW'(PRESC - 1));
        end
    endgenerate

    assign ovf_step_o = step && (&cnt_q) && !restart_i;

    // Main counter: natural wrap to zero after all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (step)           cnt_q <= cnt_q + 1'b1;
    end

    // Registered overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) time_out_o <= 1'b0;
        else        time_out_o <= ovf_step_o;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_dualclr.sv
// Watchdog timer top level.
// Combines the tick source, the clear qualifier and the counter. Halt entry
// (rising halt_i) and a qualified clear both restart the watchdog. The
// sticky time-out flag is set on overflow and cleared by either restart.
// Assumes a single clock domain clk; osc_clk_i is asynchronous.
module wdog_dualclr #(
    parameter int CNT_W = 16,
    parameter int PRESC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_osc_i,
    input  logic dual_clr_i,
    input  logic osc_clk_i,
    input  logic halt_i,
    input  logic clr_i,
    input  logic clr1_i,
    input  logic clr2_i,
    output logic time_out_o,
    output logic to_flag_o
);
    logic             halt_q;
    logic             halt_rise;
    logic             clr_fire;
    logic             restart;
    logic             tick;
    logic             ovf_step;
    logic [CNT_W-1:0] cnt_q;

    // Halt history, for detecting halt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halt_i;
    end

    assign halt_rise = halt_i & ~halt_q;
    assign restart   = clr_fire | halt_rise;

    wdog_clr_ctl u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .dual_i (dual_clr_i),
        .clr_i  (clr_i),
        .clr1_i (clr1_i),
        .clr2_i (clr2_i),
        .ovf_i  (time_out_o),
        .fire_o (clr_fire)
    );

    wdog_tick_src u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_osc_i (src_osc_i),
        .osc_clk_i (osc_clk_i),
        .halt_i    (halt_i),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wdog_count #(.CNT_W(CNT_W), .PRESC(PRESC)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .tick_i     (tick),
        .cnt_o      (cnt_q),
        .ovf_step_o (ovf_step),
        .time_out_o (time_out_o)
    );

    // Sticky time-out flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) to_flag_o <= 1'b0;
        else if (ovf_step)     to_flag_o <= 1'b1;
    end
endmodule

// File: rtl/wdog_dualclr_chk.sv
// Assertion checker for wdog_dualclr, attached with bind below.
// Observes ports plus the internal count, halt history and qualified clear.
module wdog_dualclr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_osc_i,
    input logic             dual_clr_i,
    input logic             halt_i,
    input logic             halt_q,
    input logic             clr_i,
    input logic             clr1_i,
    input logic             clr2_i,
    input logic             clr_fire,
    input logic [CNT_W-1:0] cnt_q,
    input logic             time_out_o,
    input logic             to_flag_o
);
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        time_out_o |=> !time_out_o); // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        time_out_o |-> (cnt_q == '0)); // R7
    AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        time_out_o |-> to_flag_o); // R7
    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_clr_i && clr_i) |=> (cnt_q == '0 && !to_flag_o)); // R3
    AST_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_clr_i && clr1_i && clr2_i) |=> (cnt_q == '0)); // R4
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !halt_q) |=> (cnt_q == '0 && !to_flag_o)); // R9
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && halt_q && !src_osc_i && !clr_fire) |=> $stable(cnt_q)); // R10
endmodule

bind wdog_dualclr wdog_dualclr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_osc_i  (src_osc_i),
    .dual_clr_i (dual_clr_i),
    .halt_i     (halt_i),
    .halt_q     (halt_q),
    .clr_i      (clr_i),
    .clr1_i     (clr1_i),
    .clr2_i     (clr2_i),
    .clr_fire   (clr_fire),
    .cnt_q      (cnt_q),
    .time_out_o (time_out_o),
    .to_flag_o  (to_flag_o)
);

// File: tb/wdog_dualclr_tb_top.sv
// Self-checking bench for wdog_dualclr (CNT_W=4, PRESC=2: 128-cycle period).
module wdog_dualclr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OSC_HALF   = 3 * CLK_PERIOD;   // oscillator period = 6 clk
    localparam int T_CNT_W    = 4;
    localparam int T_PRESC    = 2;
    localparam int SYS_PER    = 4 * T_PRESC * (1 << T_CNT_W);
    localparam int OSC_PER    = 6 * T_PRESC * (1 << T_CNT_W);
    localparam int WAIT_LIM   = 2000;

    // Command codes: 0 none, 1 clr, 2 clr1, 3 clr2, 4 clr1+clr2 together.
    // Vector: {dual[12], cmdA[11:9], cmdB[8:6], restart_at[5:4] (0 ref,1 A,2 B), req[3:0]}
    localparam int NVEC = 9;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 3'd1, 2'd2, 4'd3},   // R3: single clear acts
        {1'b0, 3'd2, 3'd3, 2'd0, 4'd3},   // R3: paired strobes ignored in single mode
        {1'b0, 3'd1, 3'd2, 2'd1, 4'd3},   // R3: clr acts, later clr1 ignored
        {1'b1, 3'd2, 3'd3, 2'd2, 4'd4},   // R4: clr1 then clr2
        {1'b1, 3'd3, 3'd2, 2'd2, 4'd4},   // R4: clr2 then clr1
        {1'b1, 3'd2, 3'd2, 2'd0, 4'd5},   // R5: clr1 twice
        {1'b1, 3'd1, 3'd0, 2'd0, 4'd4},   // R4: clr ignored in paired mode
        {1'b1, 3'd0, 3'd4, 2'd2, 4'd4},   // R4: both in one cycle
        {1'b1, 3'd3, 3'd3, 2'd0, 4'd5}    // R5: clr2 twice
    };

    logic clk = 1'b0, rst_n = 1'b0, osc = 1'b0;
    logic src_osc = 1'b0, dual = 1'b0, halt = 1'b0;
    logic clr = 1'b0, clr1 = 1'b0, clr2 = 1'b0;
    logic time_out, to_flag;
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    wdog_dualclr #(.CNT_W(T_CNT_W), .PRESC(T_PRESC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_osc_i(src_osc), .dual_clr_i(dual),
        .osc_clk_i(osc), .halt_i(halt), .clr_i(clr), .clr1_i(clr1),
        .clr2_i(clr2), .time_out_o(time_out), .to_flag_o(to_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #3;
        forever #(OSC_HALF) osc = ~osc;
    end
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Drive one command at a negedge; returns the index of the sampling edge.
    task automatic pulse(input int code, output int eidx);
        clr  = (code == 1);
        clr1 = (code == 2) || (code == 4);
        clr2 = (code == 3) || (code == 4);
        eidx = cyc + 1;
        step(1);
        clr = 1'b0; clr1 = 1'b0; clr2 = 1'b0;
    endtask

    // Wait until time_out is seen; returns its edge index or -1.
    task automatic wait_to(output int t);
        int n = 0;
        while (!time_out && n < WAIT_LIM) begin
            step(1);
            n++;
        end
        t = time_out ? cyc : -1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int er, ea, eb, t, t1, h, l, cnt_pulses;
        @(negedge clk);
        step(3);
        check("R8 reset flag", to_flag, 0);
        check("R7 reset pulse", time_out, 0);
        rst_n = 1'b1;
        step(2);

        // R1: exact period on the divided system clock
        pulse(1, er);
        check("R8 flag low after clear", to_flag, 0);
        wait_to(t);
        check("R1 period", t - er, SYS_PER);
        check("R7 flag set", to_flag, 1);
        step(1);
        check("R7 pulse one cycle", time_out, 0);

        // Table of clear scenarios (R3, R4, R5)
        for (int v = 0; v < NVEC; v++) begin
            logic [12:0] vec;
            int ref_e;
            vec  = VEC[v];
            dual = vec[12];
            step(1);
            pulse(vec[12] ? 4 : 1, er);
            check($sformatf("R8 flag cleared v%0d", v), to_flag, 0);
            step(40);
            pulse(int'(vec[11:9]), ea);
            step(10);
            pulse(int'(vec[8:6]), eb);
            ref_e = (vec[5:4] == 2'd0) ? er : (vec[5:4] == 2'd1) ? ea : eb;
            wait_to(t);
            check($sformatf("R%0d vector %0d", vec[3:0], v), t, ref_e + SYS_PER);
            check($sformatf("R7 flag v%0d", v), to_flag, 1);
        end

        // R6: half pair dropped on overflow
        dual = 1'b1;
        pulse(4, er);
        step(20);
        pulse(2, ea);
        wait_to(t1);
        check("R6 overflow timing", t1, er + SYS_PER);
        step(5);
        pulse(3, eb);
        wait_to(t);
        check("R6 pending dropped on overflow", t, t1 + SYS_PER);

        // R6: half pair dropped while paired mode is off
        pulse(4, er);
        step(10);
        pulse(2, ea);
        dual = 1'b0;
        step(1);
        dual = 1'b1;
        step(5);
        pulse(3, eb);
        wait_to(t);
        check("R6 pending dropped on mode exit", t, er + SYS_PER);

        // R9 / R10: halt on the divided clock
        dual = 1'b0;
        step(10);
        check("R8 flag held", to_flag, 1);
        halt = 1'b1;
        h = cyc + 1;
        step(1);
        check("R9 halt clears flag", to_flag, 0);
        cnt_pulses = 0;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (time_out) cnt_pulses++;
        end
        check("R10 frozen in halt", cnt_pulses, 0);
        halt = 1'b0;
        l = cyc + 1;
        wait_to(t);
        check("R10 resume latency", t - l, SYS_PER - 1);

        // R2: oscillator source period
        src_osc = 1'b1;
        step(2);
        pulse(1, er);
        wait_to(t);
        check_rng("R2 oscillator period", t - er, OSC_PER - 12, OSC_PER + 12);

        // R11: oscillator keeps counting through halt
        pulse(1, er);
        step(20);
        halt = 1'b1;
        h = cyc + 1;
        wait_to(t);
        check_rng("R11 time-out in halt", t - h, OSC_PER - 12, OSC_PER + 12);
        check("R11 flag in halt", to_flag, 1);
        halt = 1'b0;
        step(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule